// File: doc/BRIEF.md
# Watchdog Fail-Safe Controller

This block supervises a power driver that has four high-side and eight low-side output channels. It sits between the command sources (direct input pins and the decoded serial command stream) and the channel enables. In ordinary operation it passes the direct commands through. Once a wake or reset input rises, a watchdog is armed. The watchdog then has to be kept alive by toggling a dedicated pin or by flipping the watchdog bit in successive serial command words.

If the keep-alive stops for longer than the programmed window, the controller enters fail-safe. In fail-safe it holds high-side channels 0 and 2 on and every other channel off, whatever the commands say. The way out of fail-safe depends on whether the wake input was seen high while the watchdog ran. A strap input disables the whole supervision function.

Top module: `wdfs_ctrl`

## Requirements
- R1: With the strap `fs_en_i` high, the watchdog arms on a 0-to-1 change of `wake_i` or `hold_i`. While it is not armed, the block never enters fail-safe, and a rising edge that occurs during fail-safe does not re-arm it after exit.
- R2: A restart of the watchdog count (a kick) comes from either of two sources. One is any change of `wd_pin_i`, seen through a two-flop synchronizer. The other is a `cmd_valid_i` pulse whose `cmd_wd_bit_i` (bit 15 of the serial word) differs from the value in the previous valid word; the stored value is 0 after reset. A valid word that repeats the previous bit is not a kick.
- R3: With no kick, fail-safe is entered BASE_TICKS/2^`div_sel_i` clock cycles after arming or after the last kick. The encodings 0, 1, 2 and 3 select division by 1, 2, 4 and 8. A change of `div_sel_i` restarts the count.
- R4: In fail-safe, `mode_o` is 2, `hs_en_o` is 4'b0101 (channels 0 and 2 on), and `ls_en_o` is 0, regardless of the direct inputs.
- R5: Exit from fail-safe depends on `wake_i`. If `wake_i` was high while the watchdog was armed, the block leaves fail-safe only when `wake_i` and `hold_i` are both low. Otherwise `hold_i` low alone is enough. After exit the outputs follow R7 and R8.
- R6: With `fs_en_i` low, the block never arms and never enters fail-safe.
- R7: Outside fail-safe, with `wake_i` and `hold_i` both low, `mode_o` is 0 and all channel enables are 0.
- R8: Outside fail-safe, with `wake_i` or `hold_i` high, `mode_o` is 1. Every low-side enable equals `ls_dir_i`, and `hs_en_o[i]` equals `hs_dir_i[i]`.
- R9: While `rst_n` is low and for the cycle after release, with all inputs low, `mode_o` is 0 and every enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_i | input | 1 | Wake request level |
| hold_i | input | 1 | Device reset/enable level |
| fs_en_i | input | 1 | Strap: high enables watchdog and fail-safe |
| wd_pin_i | input | 1 | Asynchronous watchdog keep-alive pin |
| cmd_valid_i | input | 1 | One-cycle strobe for a decoded serial word |
| cmd_wd_bit_i | input | 1 | Watchdog bit (bit 15) of that word |
| div_sel_i | input | 2 | Timeout divider select |
| hs_dir_i | input | 4 | Direct commands, one per high-side channel |
| ls_dir_i | input | 1 | Shared direct command for all low-side channels |
| hs_en_o | output | 4 | Final high-side enables |
| ls_en_o | output | 8 | Final low-side enables |
| mode_o | output | 2 | 0 sleep, 1 default/normal, 2 fail-safe |

## Verification
A corrupted timeout counter shows up as fail-safe arriving early, late or never. This becomes visible on `mode_o` and `hs_en_o` one window length after the last kick, so the bench pins that edge to the exact cycle. A wrongly set wake-seen flag or armed flag shows only when fail-safe is left or entered. It appears on the cycle after `hold_i` falls, or one full window after a rising edge that should not have armed. A stale synchronizer or serial-bit register shows up as a missed or spurious kick, one window later.

// File: rtl/wdfs_pkg.sv
// Shared types for the watchdog fail-safe controller.
package wdfs_pkg;
    // Reported operating mode; the encoding is visible on the top-level port.
    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_AWAKE = 2'd1,
        MODE_FS    = 2'd2
    } wdfs_mode_e;
endpackage

// File: rtl/wdfs_kick.sv
// Keep-alive detector: turns a pin toggle or a serial watchdog-bit toggle
// into a one-cycle kick. Assumes cmd_valid_i / cmd_wd_bit_i are already
// synchronous to clk; wd_pin_i may be asynchronous.
module wdfs_kick (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_pin_i,
    input  logic cmd_valid_i,
    input  logic cmd_wd_bit_i,
    output logic kick_o
);
    logic pin_s1, pin_s2, pin_s3;
    logic ser_last;
    logic pin_tgl, ser_tgl;

    // Two-flop synchronizer plus one history flop for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
            pin_s3 <= 1'b0;
        end else begin
            pin_s1 <= wd_pin_i;
            pin_s2 <= pin_s1;
            pin_s3 <= pin_s2;
        end
    end

    // Remember the watchdog bit of the most recent valid serial word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_last <= 1'b0;
        end else if (cmd_valid_i) begin
            ser_last <= cmd_wd_bit_i;
        end
    end

    // Either source changing value counts as a kick.
    always_comb begin
        pin_tgl = pin_s2 ^ pin_s3;
        ser_tgl = cmd_valid_i & (cmd_wd_bit_i ^ ser_last);
        kick_o  = pin_tgl | ser_tgl;
    end

    // A serial word repeating the stored bit must not kick.
    AST_SER_SAME_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_wd_bit_i == ser_last && pin_s2 == pin_s3) |-> !kick_o); // R2
endmodule

// File: rtl/wdfs_timer.sv
// Watchdog window counter. Counts while armed; a kick or a change of the
// divider select restarts it. Assumes BASE_TICKS >= 16 and a power of two.
module wdfs_timer #(
    parameter int BASE_TICKS = 256,
    parameter int DIV_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             kick_i,
    input  logic [DIV_W-1:0] div_sel_i,
    output logic             timeout_o
);
    localparam int CNT_W = $clog2(BASE_TICKS);

    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] limit_m1;
    logic             div_chg;

    // Window length minus one for the currently applied divider.
    always_comb begin
        limit_m1  = CNT_W'((BASE_TICKS >> div_q) - 1);
        div_chg   = (div_sel_i != div_q);
        timeout_o = armed_i && !kick_i && !div_chg && (cnt == limit_m1);
    end

    // Register the divider so the limit and the restart change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_sel_i;
        end
    end

    // Window count: cleared when idle, kicked or re-divided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!armed_i || kick_i || div_chg || timeout_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit_m1); // R3
    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> cnt == '0); // R2
endmodule

// File: rtl/wdfs_mode.sv
// Mode sequencer: arming, fail-safe entry, and the wake-dependent exit.
// Assumes wake_i, hold_i and fs_en_i are synchronous to clk.
module wdfs_mode
    import wdfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_i,
    input  logic       hold_i,
    input  logic       fs_en_i,
    input  logic       timeout_i,
    output logic       armed_o,
    output wdfs_mode_e mode_o
);
    logic wake_q, hold_q;
    logic armed, fs_act, woke;
    logic arm_evt, asleep, exit_ok;

    // Rising-edge, sleep and exit conditions.
    always_comb begin
        arm_evt = (wake_i & ~wake_q) | (hold_i & ~hold_q);
        asleep  = ~wake_i & ~hold_i;
        exit_ok = woke ? asleep : ~hold_i;
    end

    // Input history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            wake_q <= wake_i;
            hold_q <= hold_i;
        end
    end

    // Armed / fail-safe / wake-seen state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            fs_act <= 1'b0;
            woke   <= 1'b0;
        end else if (!fs_en_i) begin
            armed  <= 1'b0;
            fs_act <= 1'b0;
            woke   <= 1'b0;
        end else if (fs_act) begin
            if (exit_ok) begin
                fs_act <= 1'b0;
                woke   <= 1'b0;
            end
        end else if (asleep) begin
            armed <= 1'b0;
            woke  <= 1'b0;
        end else if (armed && timeout_i) begin
            fs_act <= 1'b1;
            armed  <= 1'b0;
        end else begin
            if (arm_evt) armed <= 1'b1;
            if (armed && wake_i) woke <= 1'b1;
        end
    end

    // Reported mode.
    always_comb begin
        armed_o = armed;
        if (fs_act)      mode_o = MODE_FS;
        else if (asleep) mode_o = MODE_SLEEP;
        else             mode_o = MODE_AWAKE;
    end

    AST_FS_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_act) |-> $past(armed)); // R1
    AST_FS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_act && fs_en_i && hold_i) |=> fs_act); // R5
    AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en_i |=> (!fs_act && !armed)); // R6
    AST_SLEEP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !fs_act) |=> !armed); // R7
endmodule

// File: rtl/wdfs_outmux.sv
// Final channel enable selection from the mode and the direct commands.
module wdfs_outmux
    import wdfs_pkg::*;
#(
    parameter int            NUM_HS     = 4,
    parameter int            NUM_LS     = 8,
    parameter logic [NUM_HS-1:0] FS_HS_MASK = 4'b0101
) (
    input  wdfs_mode_e        mode_i,
    input  logic [NUM_HS-1:0] hs_dir_i,
    input  logic              ls_dir_i,
    output logic [NUM_HS-1:0] hs_en_o,
    output logic [NUM_LS-1:0] ls_en_o
);
    logic awake, fs;

    // Decode the mode once for all channels.
    always_comb begin
        awake = (mode_i == MODE_AWAKE);
        fs    = (mode_i == MODE_FS);
    end

    for (genvar i = 0; i < NUM_HS; i++) begin : g_hs
        // Fixed fail-safe pattern, else the channel's own direct input.
        assign hs_en_o[i] = fs ? FS_HS_MASK[i] : (awake & hs_dir_i[i]);
    end

    for (genvar j = 0; j < NUM_LS; j++) begin : g_ls
        // All low-side channels share one direct input; off in fail-safe.
        assign ls_en_o[j] = awake & ls_dir_i;
    end
endmodule

// File: rtl/wdfs_ctrl.sv
// Watchdog fail-safe controller top: kick detection, window timer, mode
// sequencer and output selection for a 4 high-side / 8 low-side driver.
module wdfs_ctrl
    import wdfs_pkg::*;
#(
    parameter int BASE_TICKS = 256,
    parameter int NUM_HS     = 4,
    parameter int NUM_LS     = 8,
    parameter int DIV_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              hold_i,
    input  logic              fs_en_i,
    input  logic              wd_pin_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_wd_bit_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic [NUM_HS-1:0] hs_dir_i,
    input  logic              ls_dir_i,
    output logic [NUM_HS-1:0] hs_en_o,
    output logic [NUM_LS-1:0] ls_en_o,
    output logic [1:0]        mode_o
);
    localparam logic [NUM_HS-1:0] FS_MASK = NUM_HS'(4'b0101);

    logic       kick, armed, timeout;
    wdfs_mode_e mode;

    wdfs_kick u_kick (
        .clk          (clk),
        .rst_n        (rst_n),
        .wd_pin_i     (wd_pin_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_wd_bit_i (cmd_wd_bit_i),
        .kick_o       (kick)
    );

    wdfs_timer #(.BASE_TICKS(BASE_TICKS), .DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed_i   (armed),
        .kick_i    (kick),
        .div_sel_i (div_sel_i),
        .timeout_o (timeout)
    );

    wdfs_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_i    (wake_i),
        .hold_i    (hold_i),
        .fs_en_i   (fs_en_i),
        .timeout_i (timeout),
        .armed_o   (armed),
        .mode_o    (mode)
    );

    wdfs_outmux #(.NUM_HS(NUM_HS), .NUM_LS(NUM_LS), .FS_HS_MASK(FS_MASK)) u_mux (
        .mode_i   (mode),
        .hs_dir_i (hs_dir_i),
        .ls_dir_i (ls_dir_i),
        .hs_en_o  (hs_en_o),
        .ls_en_o  (ls_en_o)
    );

    assign mode_o = mode;

    AST_FS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (hs_en_o == FS_MASK && ls_en_o == '0)); // R4
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (hs_en_o == '0 && ls_en_o == '0)); // R7
endmodule

// File: tb/wdfs_ctrl_test.sv
module wdfs_ctrl_test;
    localparam int L = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 0, hold = 0, fs_en = 1, pin = 0, cv = 0, cb = 0, ls_dir = 0;
    logic [1:0] div = 0;
    logic [3:0] hs_dir = 0;
    logic [3:0] hs_en;
    logic [7:0] ls_en;
    logic [1:0] mode;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdfs_ctrl #(.BASE_TICKS(L)) uut (
        .clk(clk), .rst_n(rst_n), .wake_i(wake), .hold_i(hold), .fs_en_i(fs_en),
        .wd_pin_i(pin), .cmd_valid_i(cv), .cmd_wd_bit_i(cb), .div_sel_i(div),
        .hs_dir_i(hs_dir), .ls_dir_i(ls_dir), .hs_en_o(hs_en), .ls_en_o(ls_en),
        .mode_o(mode)
    );

    // wake hold hs_dir ls_dir | exp_hs exp_ls mode  (fs_en low)
    localparam logic [20:0] VEC [6] = '{
        {1'b0, 1'b0, 4'b1111, 1'b1, 4'b0000, 8'h00, 2'd0},
        {1'b1, 1'b0, 4'b1010, 1'b1, 4'b1010, 8'hFF, 2'd1},
        {1'b0, 1'b1, 4'b0101, 1'b0, 4'b0101, 8'h00, 2'd1},
        {1'b1, 1'b1, 4'b0000, 1'b1, 4'b0000, 8'hFF, 2'd1},
        {1'b0, 1'b1, 4'b1111, 1'b0, 4'b1111, 8'h00, 2'd1},
        {1'b0, 1'b0, 4'b0000, 1'b1, 4'b0000, 8'h00, 2'd0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 0; wake = 0; hold = 0; fs_en = strap; pin = 0; cv = 0; cb = 0;
        div = 0; hs_dir = 4'b1111; ls_dir = 1;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        do_reset(1'b1);
        chk("R9 mode", mode, 0);
        chk("R9 hs", hs_en, 0);
        chk("R9 ls", ls_en, 0);

        // table: default and sleep pass-through with strap low
        fs_en = 0;
        for (int k = 0; k < 6; k++) begin
            {wake, hold, hs_dir, ls_dir} = VEC[k][20:14];
            tick(1);
            chk("R8/R7 vec hs", hs_en, VEC[k][13:10]);
            chk("R8/R7 vec ls", ls_en, VEC[k][9:2]);
            chk("R8/R7 vec mode", mode, VEC[k][1:0]);
        end

        // R3 R4: armed by hold, exact window, fail-safe pattern
        do_reset(1'b1);
        hold = 1;
        tick(L - 1);
        chk("R3 before window", mode, 1);
        chk("R8 hs follows", hs_en, 4'b1111);
        tick(2);
        chk("R3 after window", mode, 2);
        chk("R4 hs", hs_en, 4'b0101);
        chk("R4 ls", ls_en, 0);
        // R5: wake never high while armed -> hold low alone exits
        wake = 1;
        tick(2);
        chk("R5 still fs", mode, 2);
        hold = 0;
        tick(1);
        chk("R5 exit by hold", mode, 1);
        chk("R5 hs after exit", hs_en, 4'b1111);
        tick(L + 4);
        chk("R1 no rearm", mode, 1);

        // R5: wake seen high -> both must be low
        do_reset(1'b1);
        wake = 1; hold = 1;
        tick(L + 1);
        chk("R1 armed by rise", mode, 2);
        hold = 0;
        tick(3);
        chk("R5 hold alone keeps fs", mode, 2);
        wake = 0;
        tick(1);
        chk("R5 both low exit", mode, 0);
        chk("R7 sleep dark", ls_en, 0);

        // R2: pin kicks keep it alive
        do_reset(1'b1);
        hold = 1;
        for (int k = 0; k < 8; k++) begin
            tick(L / 2);
            pin = ~pin;
        end
        chk("R2 pin alive", mode, 1);
        tick(L + 4);
        chk("R2 no kick times out", mode, 2);

        // R2: serial bit toggles keep it alive, repeated bit does not
        do_reset(1'b1);
        hold = 1;
        for (int k = 0; k < 8; k++) begin
            tick(L / 2 - 1);
            cb = (k % 2 == 0); cv = 1;
            tick(1);
            cv = 0;
        end
        chk("R2 serial alive", mode, 1);
        for (int k = 0; k < 4; k++) begin
            tick(L / 2 - 1);
            cb = 0; cv = 1;
            tick(1);
            cv = 0;
        end
        chk("R2 repeated bit ignored", mode, 2);

        // R3: divide by 8
        do_reset(1'b1);
        div = 3;
        tick(2);
        hold = 1;
        tick(L / 8 - 1);
        chk("R3 div8 before", mode, 1);
        tick(2);
        chk("R3 div8 after", mode, 2);

        // R3: divider change restarts the window
        do_reset(1'b1);
        hold = 1;
        tick(40);
        div = 1;
        tick(L / 2 - 1);
        chk("R3 restart before", mode, 1);
        tick(2);
        chk("R3 restart after", mode, 2);

        // R6: strap low disables supervision
        do_reset(1'b0);
        wake = 1; hold = 1;
        tick(L + 4);
        chk("R6 no fail-safe", mode, 1);
        chk("R6 hs follows", hs_en, 4'b1111);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule